// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Frame Receiver

This block recovers characters from a single asynchronous serial line. A tick enable supplied from outside pulses once per sample period, at sixteen times the bit rate. The receiver first waits for the line to stay high for a full bit time. It then hunts for a falling edge. Half a bit later it confirms that the line is still low, which locks the sampling phase to the incoming character to within one sixteenth of a bit. The data, parity and stop bits are then each read near their centres, one bit time apart.

The character length, the parity mode and the number of stop bits are set on static configuration inputs. A finished character is presented on a valid/ready output together with three flags: parity mismatch, framing error and break. The line cannot be paused, so the output accepts no back-pressure into the receiver. `out_valid` stays high, and the data and flags stay frozen, until `out_ready` is seen high at a clock edge. If another character completes while one is still pending, the new one replaces the old one. A character and its flags travel together as one item.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset `out_valid`, `par_err`, `frm_err` and `brk` are low. A start edge is accepted only after the synchronised line has been high for 16 consecutive sample ticks. The same rule applies after any frame that ended with a low stop sample.
- R2: A falling edge is confirmed 8 ticks later. If the line is high at that point, the event is dropped without any output and the receiver returns to hunting for an edge.
- R3: Data bits are sampled every 16 ticks, starting from the confirmed start midpoint, and are assembled least significant bit first. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and unused upper output bits are zero. The line sequence 0,1,1,0,0,0,0,0,0,1 yields 0x03 with no flags.
- R4: `cfg_par` value 0 or 3 selects no parity bit, 1 selects even parity and 2 selects odd parity. For even parity the data bits and the parity bit together hold an even number of ones; for odd parity they hold an odd number. A mismatch raises `par_err` with that character. With no parity, `par_err` stays low.
- R5: `cfg_stop` value 0 selects one stop bit, 1 selects one and a half, and 2 or 3 select two. Each stop bit is sampled at its centre, and any low stop sample raises `frm_err`.
- R6: If every sample of a frame is low, from the start bit through the last stop bit, the character is reported with `brk` high, `frm_err` and `par_err` low, and data zero.
- R7: With one or two stop bits, the receiver re-arms for a new start edge at the centre of the last stop bit. With one and a half stop bits, it re-arms 8 ticks after the centre of the first stop bit. A new start edge 10 ticks into a single stop bit is therefore received.
- R8: A finished character raises `out_valid` one cycle after its last sample. Data and flags hold unchanged until a cycle in which `out_valid` and `out_ready` are both high, after which `out_valid` drops. A character completing while another is pending overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable, 16 pulses per bit time |
| rxd_in | input | 1 | Serial line, idle high, asynchronous to clk |
| cfg_len | input | 2 | Data length select (5 + value bits) |
| cfg_par | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| cfg_stop | input | 2 | Stop bits: 0 one, 1 one and a half, 2/3 two |
| out_valid | output | 1 | Character available |
| out_ready | input | 1 | Consumer accepts the character |
| out_data | output | 8 | Received character, LSB first on the line |
| par_err | output | 1 | Parity mismatch for this character |
| frm_err | output | 1 | Low stop sample for this character |
| brk | output | 1 | All-low frame, reported as break |

## Verification
The assertions check the output handshake on every cycle. They cover holding and freezing a pending character, dropping it after a transfer, and loading it after completion. They also check that break excludes the other flags and carries zero data, that upper data bits are zero for the selected length, and that the parity flag stays low with parity disabled. The following can only be shown by the bench's scenarios, by driving timed line waveforms and watching which characters appear: sampling at bit centres, rejection of short low glitches, the idle wait before arming, each length, parity and stop setting, and early re-arming inside a shortened stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_QUAL,
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HALF
  } rx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
  localparam logic [1:0] STOP_ONE_HALF = 2'd1;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= 1'b1;
        else if (g == 0) pipe[g] <= din;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_idle_qual.sv
module uart_rx_idle_qual #(
  parameter int IDLE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic enable,
  output logic qualified
);
  localparam int QW = $clog2(IDLE_TICKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(IDLE_TICKS);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!enable) run_q <= '0;
    else if (tick) begin
      if (!line) run_q <= '0;
      else if (run_q != QMAX) run_q <= run_q + 1'b1;
    end
  end

  assign qualified = (run_q == QMAX);
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 8,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                line,
  input  logic                qualified,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic [1:0]          cfg_stop,
  output logic                in_qual,
  output logic                done,
  output logic [DATA_MAX-1:0] res_data,
  output logic                res_perr,
  output logic                res_ferr,
  output logic                res_brk
);
  localparam int CNT_W    = $clog2(OSR);
  localparam int HALF     = OSR / 2;
  localparam int IDX_W    = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1;
  localparam int MIN_BITS = DATA_MAX - (2**LEN_W) + 1;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OSR - 1);

  rx_state_e           state, st_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [IDX_W-1:0]    bidx, bidx_n, last_idx;
  logic [DATA_MAX-1:0] shreg, sh_n;
  logic                par_bit, par_n;
  logic                any_high, any_n;
  logic                stop_low, slow_n;
  logic                sidx, sidx_n;
  logic                fin, par_en, ones, mismatch, brk_n;

  assign par_en   = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
  assign in_qual  = (state == ST_QUAL);

  always_comb begin
    st_n   = state;
    cnt_n  = cnt;
    bidx_n = bidx;
    sh_n   = shreg;
    par_n  = par_bit;
    any_n  = any_high;
    slow_n = stop_low;
    sidx_n = sidx;
    fin    = 1'b0;
    if (tick) begin
      case (state)
        ST_QUAL: if (qualified) st_n = ST_HUNT;
        ST_HUNT: if (!line) begin
          st_n  = ST_START;
          cnt_n = '0;
        end
        ST_START: begin
          if (cnt == CNT_HALF) begin
            cnt_n = '0;
            if (!line) begin
              st_n   = ST_DATA;
              bidx_n = '0;
              sh_n   = '0;
              any_n  = 1'b0;
              slow_n = 1'b0;
              sidx_n = 1'b0;
              par_n  = 1'b0;
            end else begin
              st_n = ST_HUNT;
            end
          end else cnt_n = cnt + 1'b1;
        end
        ST_DATA: begin
          if (cnt == CNT_FULL) begin
            cnt_n      = '0;
            sh_n[bidx] = line;
            any_n      = any_high | line;
            if (bidx == last_idx) st_n = par_en ? ST_PAR : ST_STOP;
            else bidx_n = bidx + 1'b1;
          end else cnt_n = cnt + 1'b1;
        end
        ST_PAR: begin
          if (cnt == CNT_FULL) begin
            cnt_n = '0;
            par_n = line;
            any_n = any_high | line;
            st_n  = ST_STOP;
          end else cnt_n = cnt + 1'b1;
        end
        ST_STOP: begin
          if (cnt == CNT_FULL) begin
            cnt_n  = '0;
            slow_n = stop_low | !line;
            any_n  = any_high | line;
            if (!sidx && cfg_stop == STOP_ONE_HALF) st_n = ST_HALF;
            else if (!sidx && cfg_stop[1]) sidx_n = 1'b1;
            else fin = 1'b1;
          end else cnt_n = cnt + 1'b1;
        end
        ST_HALF: begin
          if (cnt == CNT_HALF) begin
            cnt_n = '0;
            fin   = 1'b1;
          end else cnt_n = cnt + 1'b1;
        end
        default: st_n = ST_QUAL;
      endcase
      if (fin) st_n = slow_n ? ST_QUAL : ST_HUNT;
    end
  end

  assign ones     = (^sh_n) ^ par_n;
  assign mismatch = (cfg_par == PAR_ODD) ? !ones : ones;
  assign brk_n    = !any_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_QUAL;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      any_high <= 1'b0;
      stop_low <= 1'b0;
      sidx     <= 1'b0;
      done     <= 1'b0;
      res_data <= '0;
      res_perr <= 1'b0;
      res_ferr <= 1'b0;
      res_brk  <= 1'b0;
    end else begin
      state    <= st_n;
      cnt      <= cnt_n;
      bidx     <= bidx_n;
      shreg    <= sh_n;
      par_bit  <= par_n;
      any_high <= any_n;
      stop_low <= slow_n;
      sidx     <= sidx_n;
      done     <= fin;
      if (fin) begin
        res_data <= brk_n ? '0 : sh_n;
        res_brk  <= brk_n;
        res_ferr <= slow_n & !brk_n;
        res_perr <= par_en & mismatch & !brk_n;
      end
    end
  end
endmodule

// File: rtl/uart_rx_outbuf.sv
module uart_rx_outbuf #(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                in_perr,
  input  logic                in_ferr,
  input  logic                in_brk,
  input  logic                ready,
  output logic                valid,
  output logic [DATA_MAX-1:0] data,
  output logic                perr,
  output logic                ferr,
  output logic                brk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      brk   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= in_data;
      perr  <= in_perr;
      ferr  <= in_ferr;
      brk   <= in_brk;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int OSR        = 16,
  parameter int DATA_MAX   = 8,
  parameter int LEN_W      = 2,
  parameter int IDLE_TICKS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                rxd_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic [1:0]          cfg_stop,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_MAX-1:0] out_data,
  output logic                par_err,
  output logic                frm_err,
  output logic                brk
);
  logic                line_s, qualified, in_qual, frame_done;
  logic [DATA_MAX-1:0] res_data;
  logic                res_perr, res_ferr, res_brk;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd_in), .dout(line_s)
  );

  uart_rx_idle_qual #(.IDLE_TICKS(IDLE_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .enable(in_qual), .qualified(qualified)
  );

  uart_rx_engine #(.OSR(OSR), .DATA_MAX(DATA_MAX), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .qualified(qualified), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .in_qual(in_qual), .done(frame_done),
    .res_data(res_data), .res_perr(res_perr), .res_ferr(res_ferr),
    .res_brk(res_brk)
  );

  uart_rx_outbuf #(.DATA_MAX(DATA_MAX)) u_out (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .in_data(res_data),
    .in_perr(res_perr), .in_ferr(res_ferr), .in_brk(res_brk),
    .ready(out_ready), .valid(out_valid), .data(out_data),
    .perr(par_err), .ferr(frm_err), .brk(brk)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DATA_MAX = 8,
  parameter int LEN_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LEN_W-1:0]    cfg_len,
  input logic [1:0]          cfg_par,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_MAX-1:0] out_data,
  input logic                par_err,
  input logic                frm_err,
  input logic                brk,
  input logic                frame_done
);
  localparam int MIN_BITS = DATA_MAX - (2**LEN_W) + 1;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_done) |=>
      ($stable(out_data) && $stable(par_err) && $stable(frm_err) && $stable(brk)));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_done) |=> !out_valid);

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid);

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(brk && (frm_err || par_err)));

  assert_brkdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && brk) |-> (out_data == '0));

  assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> (MIN_BITS + int'(cfg_len))) == '0));

  assert_nopar_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(cfg_par == 2'd1 || cfg_par == 2'd2)) |-> !par_err);
endmodule

bind uart_frame_rx uart_rx_chk #(.DATA_MAX(DATA_MAX), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par(cfg_par),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .par_err(par_err), .frm_err(frm_err), .brk(brk), .frame_done(frame_done)
);

// File: tb/tb_uart_frame_rx.sv
`timescale 1ns/1ps
module tb_uart_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       tick16;
  logic       rxd_in = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
  logic       out_valid, out_ready = 1'b1;
  logic [7:0] out_data;
  logic       par_err, frm_err, brk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  uart_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_in(rxd_in),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .par_err(par_err), .frm_err(frm_err), .brk(brk)
  );

  logic [7:0] cap_d [0:63];
  logic [2:0] cap_f [0:63];
  int cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (cap_n < 64) begin
        cap_d[cap_n] = out_data;
        cap_f[cap_n] = {par_err, frm_err, brk};
      end
      cap_n++;
    end
  end

  typedef struct packed {
    logic [2:0] req;
    logic [1:0] len;
    logic [1:0] par;
    logic [1:0] stp;
    logic [7:0] d;
    logic       flip;
    logic       lowstop;
    logic [7:0] ed;
    logic       epe;
    logic       efe;
    logic       ebrk;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 2'd3, 2'd0, 2'd0, 8'h03, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0}, // R3 0x03 example
    '{3'd3, 2'd3, 2'd0, 2'd0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0}, // R3
    '{3'd3, 2'd0, 2'd0, 2'd0, 8'h1B, 1'b0, 1'b0, 8'h1B, 1'b0, 1'b0, 1'b0}, // R3 5 bits
    '{3'd3, 2'd1, 2'd0, 2'd0, 8'h2D, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0, 1'b0}, // R3 6 bits
    '{3'd3, 2'd2, 2'd0, 2'd0, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0}, // R3 7 bits
    '{3'd4, 2'd3, 2'd1, 2'd0, 8'h07, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0}, // R4 even ok
    '{3'd4, 2'd3, 2'd1, 2'd0, 8'h07, 1'b1, 1'b0, 8'h07, 1'b1, 1'b0, 1'b0}, // R4 even bad
    '{3'd4, 2'd3, 2'd2, 2'd0, 8'h07, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0}, // R4 odd ok
    '{3'd4, 2'd3, 2'd2, 2'd0, 8'h07, 1'b1, 1'b0, 8'h07, 1'b1, 1'b0, 1'b0}, // R4 odd bad
    '{3'd5, 2'd3, 2'd0, 2'd0, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0}, // R5 low stop
    '{3'd5, 2'd3, 2'd0, 2'd2, 8'hC3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0}, // R5 two stops
    '{3'd5, 2'd3, 2'd0, 2'd2, 8'hC3, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0}, // R5 two low
    '{3'd5, 2'd3, 2'd0, 2'd1, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0}, // R5 one and a half
    '{3'd5, 2'd3, 2'd0, 2'd3, 8'h7E, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0, 1'b0}, // R5 code 3
    '{3'd6, 2'd3, 2'd1, 2'd2, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1}, // R6 break
    '{3'd6, 2'd3, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1}  // R6 break
  };

  function automatic string req_name(input logic [2:0] r);
    case (r)
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic [1:0] par,
                            input logic [1:0] stp, input bit flip, input bit lowstop,
                            input int one_stop_ticks);
    logic p;
    rxd_in = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      rxd_in = d[i];
      wait_ticks(16);
    end
    if (par == 2'd1 || par == 2'd2) begin
      p = ^d;
      if (par == 2'd2) p = !p;
      if (flip) p = !p;
      rxd_in = p;
      wait_ticks(16);
    end
    rxd_in = !lowstop;
    if (stp == 2'd0) wait_ticks(one_stop_ticks);
    else if (stp == 2'd1) wait_ticks(24);
    else wait_ticks(32);
    rxd_in = 1'b1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!out_valid && !par_err && !frm_err && !brk, "R1", "reset outputs",
          {12'd0, out_valid, par_err, frm_err, brk}, 16'd0);

    // R1: line low then only 10 idle ticks before a frame: nothing received
    base = cap_n;
    wait_ticks(40);
    rxd_in = 1'b1;
    wait_ticks(10);
    send_frame(8'h00, 8, 2'd0, 2'd0, 0, 0, 16);
    wait_ticks(24);
    check(cap_n == base, "R1", "no output without idle qualification",
          16'(cap_n - base), 16'd0);

    // R2: short low glitch is ignored
    base = cap_n;
    rxd_in = 1'b0;
    wait_ticks(5);
    rxd_in = 1'b1;
    wait_ticks(30);
    check(cap_n == base, "R2", "glitch dropped", 16'(cap_n - base), 16'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      cfg_len = VECS[v].len;
      cfg_par = VECS[v].par;
      cfg_stop = VECS[v].stp;
      base = cap_n;
      send_frame(VECS[v].d, 5 + int'(VECS[v].len), VECS[v].par, VECS[v].stp,
                 VECS[v].flip, VECS[v].lowstop, 16);
      wait_ticks(24);
      if (cap_n != base + 1)
        check(0, req_name(VECS[v].req), $sformatf("vector %0d count", v),
              16'(cap_n - base), 16'd1);
      else
        check(cap_d[base] == VECS[v].ed &&
              cap_f[base] == {VECS[v].epe, VECS[v].efe, VECS[v].ebrk},
              req_name(VECS[v].req), $sformatf("vector %0d data/flags", v),
              {5'd0, cap_f[base], cap_d[base]},
              {5'd0, VECS[v].epe, VECS[v].efe, VECS[v].ebrk, VECS[v].ed});
    end
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd0;

    // R2: glitch followed by a real frame is still received
    base = cap_n;
    rxd_in = 1'b0;
    wait_ticks(6);
    rxd_in = 1'b1;
    wait_ticks(20);
    send_frame(8'h69, 8, 2'd0, 2'd0, 0, 0, 16);
    wait_ticks(24);
    check(cap_n == base + 1 && cap_d[base] == 8'h69, "R2", "frame after glitch",
          {8'(cap_n - base), cap_d[base]}, 16'h0169);

    // R7: stop bit cut to 10 ticks, next start follows at once
    base = cap_n;
    send_frame(8'h3C, 8, 2'd0, 2'd0, 0, 0, 10);
    send_frame(8'h96, 8, 2'd0, 2'd0, 0, 0, 16);
    wait_ticks(24);
    check(cap_n == base + 2, "R7", "two frames with short stop",
          16'(cap_n - base), 16'd2);
    check(cap_d[base] == 8'h3C && cap_d[base+1] == 8'h96 &&
          cap_f[base] == 3'b000 && cap_f[base+1] == 3'b000,
          "R7", "short stop data", {cap_d[base], cap_d[base+1]}, 16'h3C96);

    // R8: hold while not ready, then drop after transfer
    out_ready = 1'b0;
    send_frame(8'h11, 8, 2'd0, 2'd0, 0, 0, 16);
    wait_ticks(24);
    check(out_valid && out_data == 8'h11, "R8", "held while not ready",
          {7'd0, out_valid, out_data}, 16'h0111);
    wait_ticks(40);
    check(out_valid && out_data == 8'h11, "R8", "still held",
          {7'd0, out_valid, out_data}, 16'h0111);
    #1 out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R8", "drop after transfer", {15'd0, out_valid}, 16'd0);

    // R8: pending character replaced by a newer one
    out_ready = 1'b0;
    send_frame(8'h22, 8, 2'd0, 2'd0, 0, 0, 16);
    wait_ticks(24);
    send_frame(8'h33, 8, 2'd0, 2'd0, 0, 0, 16);
    wait_ticks(24);
    check(out_valid && out_data == 8'h33, "R8", "overwrite pending",
          {7'd0, out_valid, out_data}, 16'h0133);
    #1 out_ready = 1'b1;
    wait_ticks(4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule